// File: doc/BRIEF.md
# Binary to Quinary Symbol Mapper and Demapper

This block converts 16-bit binary words into groups of seven base-5 digits for a three-wire link whose clock is carried in its symbol transitions, and converts received groups of seven digits back into words. Five values per symbol are enough, because 5^7 = 78125 is not smaller than 2^16 = 65536. The grouping therefore carries 16/7, about 2.28 bits per symbol, which is just below the log2(5), about 2.32, bound for a five-valued alphabet.

The transmit half accepts a word on a valid/ready handshake. It then produces one digit on each symbol strobe, most significant digit first, using compare-and-subtract against descending powers of five. The receive half multiplies an accumulator by five and adds each incoming digit. After the seventh digit it presents the word with a one-cycle valid pulse. If the seven digits encode a value that a 16-bit word cannot hold, it raises an error flag. A synchronous resync input drops any partly collected group. Both halves share a clock and a reset but otherwise run independently. Wire-state encoding, serialisation and clock recovery belong to the surrounding logic.

Top module: `quinary_codec`

## Requirements
- R1: Every digit the mapper issues, and every digit the demapper accepts, lies in the range 0 to 4, carried as a 3-bit unsigned value.
- R2: Each accepted word W is issued as exactly seven digits d0..d6 in that order, with W = d0*5^6 + d1*5^5 + ... + d6*5^0, so d0 is the most significant.
- R3: `tx_ready` falls in the cycle after a word is accepted and stays low until the strobe that issues the seventh digit. It is high again in the following cycle.
- R4: A word is accepted only in a cycle where `tx_valid` and `tx_ready` are both high. A strobe while no group is in progress, or in the cycle a word is accepted, issues no digit.
- R5: A strobe during a group produces `tx_sym_vld` high for exactly the next cycle, with the digit on `tx_sym` in that same cycle.
- R6: The cycle after the seventh valid digit of a group arrives, `rx_word_vld` is high for one cycle and `rx_word` holds the low 16 bits of the decoded value. `rx_word` and `rx_word_err` hold until the next completed group.
- R7: `rx_word_err` is high with `rx_word_vld` exactly when the decoded value of the seven digits is 65536 or more.
- R8: When `rx_resync` is high, the digits collected so far are discarded, a digit presented in that same cycle is ignored, and the next valid digit starts a new group.
- R9: A word sent through the mapper, with its digits fed straight into the demapper, comes back unchanged and without error.
- R10: During reset `tx_ready` is high, and `tx_sym_vld`, `rx_word_vld` and `rx_word_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid | input | 1 | Word offered to the mapper |
| tx_data | input | 16 | Word to convert |
| tx_ready | output | 1 | Mapper can take a word |
| sym_stb | input | 1 | Symbol strobe: request the next digit |
| tx_sym | output | 3 | Issued digit, 0 to 4 |
| tx_sym_vld | output | 1 | `tx_sym` is valid this cycle |
| rx_resync | input | 1 | Drop any partial receive group |
| rx_sym | input | 3 | Received digit, 0 to 4 |
| rx_sym_vld | input | 1 | `rx_sym` is valid this cycle |
| rx_word | output | 16 | Decoded word |
| rx_word_vld | output | 1 | One-cycle pulse: `rx_word` is new |
| rx_word_err | output | 1 | Decoded value did not fit 16 bits |

## Verification
The demapper's assertions assume that every digit presented with `rx_sym_vld` lies in 0 to 4. Digits 5 to 7 are outside the alphabet, and the accumulator bound does not cover them. The stimulus keeps to this: in loopback the demapper only sees digits the mapper produced, and the directly driven groups use only in-range digits, including all-fours and the digit string for 65536. The mapper's bound on its remaining value needs no input assumption, since any 16-bit word is below 5^7.

// File: rtl/qmap_pkg.sv
// Shared constants and helpers for the quinary mapper and demapper.
// Assumes the radix and group length give RADIX^DIGITS >= 2^WORD_W.
package qmap_pkg;

    localparam int QM_WORD_W = 16;
    localparam int QM_DIGITS = 7;
    localparam int QM_RADIX  = 5;

    // Integer power used to size accumulators and build weight tables.
    function automatic longint radix_pow(input int r, input int n);
        longint p;
        p = 1;
        for (int i = 0; i < n; i++) begin
            p = p * r;
        end
        return p;
    endfunction

endpackage

// File: rtl/qmap_digit_sel.sv
// Picks the next most significant digit from a remaining value and the
// weight of the digit position, and returns the value left after removal.
// Assumes rem < weight * RADIX, so the digit fits below RADIX.
module qmap_digit_sel #(
    parameter int ACC_W = 17,
    parameter int SYM_W = 3,
    parameter int RADIX = 5
) (
    input  logic [ACC_W-1:0] rem,
    input  logic [ACC_W-1:0] weight,
    output logic [SYM_W-1:0] digit,
    output logic [ACC_W-1:0] rem_next
);

    localparam int PW = ACC_W + SYM_W;

    logic [RADIX-2:0] ge;
    logic [PW-1:0]    taken;

    // One comparator per candidate digit value 1..RADIX-1.
    for (genvar d = 1; d < RADIX; d++) begin : g_cmp
        assign ge[d-1] = PW'(rem) >= (PW'(d) * PW'(weight));
    end

    // Thermometer count of passed comparisons gives the digit; subtract its weight.
    always_comb begin
        digit    = SYM_W'($countones(ge));
        taken    = PW'(digit) * PW'(weight);
        rem_next = rem - taken[ACC_W-1:0];
    end

endmodule

// File: rtl/qmap_mac.sv
// Multiply-by-radix and add step for the demapper accumulator.
// Assumes the caller keeps acc_in below RADIX^(DIGITS-1) so the result fits.
module qmap_mac #(
    parameter int ACC_W = 17,
    parameter int SYM_W = 3,
    parameter int RADIX = 5
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic [SYM_W-1:0] sym,
    output logic [ACC_W-1:0] acc_out
);

    localparam int PW = ACC_W + SYM_W;

    logic [PW-1:0] scaled;

    // Shift the accumulated digits up one place and append the new one.
    always_comb begin
        scaled  = PW'(acc_in) * PW'(RADIX);
        acc_out = scaled[ACC_W-1:0] + ACC_W'(sym);
    end

endmodule

// File: rtl/qmap_tx.sv
// Mapper: takes a binary word on valid/ready and issues its base-RADIX
// digits, most significant first, one per symbol strobe. Ready stays low
// for the whole group. Assumes sym_stb is a single-cycle request.
module qmap_tx
    import qmap_pkg::*;
#(
    parameter int WORD_W = QM_WORD_W,
    parameter int DIGITS = QM_DIGITS,
    parameter int RADIX  = QM_RADIX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              sym_stb,
    output logic [$clog2(RADIX)-1:0] sym_out,
    output logic              sym_vld
);

    localparam int SYM_W = $clog2(RADIX);
    localparam int ACC_W = $clog2(radix_pow(RADIX, DIGITS));
    localparam int IDX_W = $clog2(DIGITS);
    localparam int PW    = ACC_W + SYM_W;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DIGITS - 1);

    logic [ACC_W-1:0] wtab [DIGITS];
    logic             busy;
    logic [IDX_W-1:0] idx;
    logic [ACC_W-1:0] rem;
    logic [ACC_W-1:0] rem_nx;
    logic [SYM_W-1:0] dig;
    logic [SYM_W-1:0] sym_q;
    logic             vld_q;

    // Weight of each digit position, most significant position first.
    for (genvar i = 0; i < DIGITS; i++) begin : g_w
        assign wtab[i] = ACC_W'(radix_pow(RADIX, DIGITS - 1 - i));
    end

    qmap_digit_sel #(
        .ACC_W (ACC_W),
        .SYM_W (SYM_W),
        .RADIX (RADIX)
    ) u_sel (
        .rem      (rem),
        .weight   (wtab[idx]),
        .digit    (dig),
        .rem_next (rem_nx)
    );

    // Group sequencing: load on handshake, step one digit per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
            rem  <= '0;
        end else if (busy) begin
            if (sym_stb) begin
                rem <= rem_nx;
                if (idx == LAST) begin
                    busy <= 1'b0;
                    idx  <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end else if (in_valid) begin
            busy <= 1'b1;
            idx  <= '0;
            rem  <= ACC_W'(in_data);
        end
    end

    // Output register: one-cycle digit pulse per serviced strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= busy && sym_stb;
            if (busy && sym_stb) begin
                sym_q <= dig;
            end
        end
    end

    assign in_ready = !busy;
    assign sym_out  = sym_q;
    assign sym_vld  = vld_q;

    // Remaining value always fits the digits still to be issued.
    p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (PW'(rem) < PW'(wtab[idx]) * PW'(RADIX)));

    // Issued digits stay inside the alphabet.
    p_sym_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |-> (sym_out < SYM_W'(RADIX)));

    // Ready drops right after a word is taken.
    p_ready_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // Ready returns right after the last digit is requested.
    p_ready_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sym_stb && idx == LAST) |=> in_ready);

    // A digit pulse always answers a strobe one cycle earlier.
    p_sym_follows_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sym_vld) |-> $past(sym_stb));

endmodule

// File: rtl/qmap_rx.sv
// Demapper: accumulates DIGITS base-RADIX digits, most significant first,
// and outputs the word with a one-cycle valid pulse plus a range error flag.
// Assumes every digit presented with sym_in_vld is below RADIX.
module qmap_rx
    import qmap_pkg::*;
#(
    parameter int WORD_W = QM_WORD_W,
    parameter int DIGITS = QM_DIGITS,
    parameter int RADIX  = QM_RADIX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resync,
    input  logic [$clog2(RADIX)-1:0] sym_in,
    input  logic              sym_in_vld,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld,
    output logic              word_err
);

    localparam int SYM_W = $clog2(RADIX);
    localparam int ACC_W = $clog2(radix_pow(RADIX, DIGITS));
    localparam int IDX_W = $clog2(DIGITS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DIGITS - 1);

    logic [ACC_W-1:0] ptab [DIGITS];
    logic [IDX_W-1:0] cnt;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_nx;
    logic [WORD_W-1:0] word_q;
    logic             vld_q;
    logic             err_q;

    // Upper bound of the accumulator after j collected digits.
    for (genvar j = 0; j < DIGITS; j++) begin : g_p
        assign ptab[j] = ACC_W'(radix_pow(RADIX, j));
    end

    qmap_mac #(
        .ACC_W (ACC_W),
        .SYM_W (SYM_W),
        .RADIX (RADIX)
    ) u_mac (
        .acc_in  (acc),
        .sym     (sym_in),
        .acc_out (acc_nx)
    );

    // Digit collection with resync taking priority over an incoming digit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            acc <= '0;
        end else if (resync) begin
            cnt <= '0;
            acc <= '0;
        end else if (sym_in_vld) begin
            if (cnt == LAST) begin
                cnt <= '0;
                acc <= '0;
            end else begin
                cnt <= cnt + 1'b1;
                acc <= acc_nx;
            end
        end
    end

    // Result register: word, range flag and single-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            err_q  <= 1'b0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= !resync && sym_in_vld && (cnt == LAST);
            if (!resync && sym_in_vld && cnt == LAST) begin
                word_q <= acc_nx[WORD_W-1:0];
                err_q  <= |acc_nx[ACC_W-1:WORD_W];
            end
        end
    end

    assign word_out = word_q;
    assign word_vld = vld_q;
    assign word_err = err_q;

    // Input assumption: digits are inside the alphabet.
    p_sym_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sym_in_vld |-> (sym_in < SYM_W'(RADIX)));

    // Accumulator never exceeds what cnt digits can encode.
    p_acc_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc < ptab[cnt]);

    // Word valid is a single-cycle pulse.
    p_vld_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    // A resync cycle never completes a word.
    p_resync_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> !word_vld);

    // Error flag only changes when a new word is presented.
    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> $stable(word_err));

endmodule

// File: rtl/quinary_codec.sv
// Top level: binary-to-quinary mapper and quinary-to-binary demapper on a
// shared clock and reset. The two halves have no internal connection.
module quinary_codec
    import qmap_pkg::*;
#(
    parameter int WORD_W = QM_WORD_W,
    parameter int DIGITS = QM_DIGITS,
    parameter int RADIX  = QM_RADIX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic              sym_stb,
    output logic [$clog2(RADIX)-1:0] tx_sym,
    output logic              tx_sym_vld,
    input  logic              rx_resync,
    input  logic [$clog2(RADIX)-1:0] rx_sym,
    input  logic              rx_sym_vld,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_word_vld,
    output logic              rx_word_err
);

    qmap_tx #(
        .WORD_W (WORD_W),
        .DIGITS (DIGITS),
        .RADIX  (RADIX)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (tx_valid),
        .in_data  (tx_data),
        .in_ready (tx_ready),
        .sym_stb  (sym_stb),
        .sym_out  (tx_sym),
        .sym_vld  (tx_sym_vld)
    );

    qmap_rx #(
        .WORD_W (WORD_W),
        .DIGITS (DIGITS),
        .RADIX  (RADIX)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .resync     (rx_resync),
        .sym_in     (rx_sym),
        .sym_in_vld (rx_sym_vld),
        .word_out   (rx_word),
        .word_vld   (rx_word_vld),
        .word_err   (rx_word_err)
    );

endmodule

// File: tb/sim_quinary_codec.sv
`timescale 1ns/1ps
module sim_quinary_codec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_ready;
    logic        sym_stb = 1'b0;
    logic [2:0]  tx_sym;
    logic        tx_sym_vld;
    logic        rx_resync = 1'b0;
    logic [2:0]  rx_sym;
    logic        rx_sym_vld;
    logic [15:0] rx_word;
    logic        rx_word_vld;
    logic        rx_word_err;

    logic        lb = 1'b0;
    logic [2:0]  drv_sym = '0;
    logic        drv_vld = 1'b0;
    int          stb_period = 0;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int err_seen = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign rx_sym     = lb ? tx_sym : drv_sym;
    assign rx_sym_vld = lb ? tx_sym_vld : drv_vld;

    quinary_codec u0 (
        .clk (clk), .rst_n (rst_n),
        .tx_valid (tx_valid), .tx_data (tx_data), .tx_ready (tx_ready),
        .sym_stb (sym_stb), .tx_sym (tx_sym), .tx_sym_vld (tx_sym_vld),
        .rx_resync (rx_resync), .rx_sym (rx_sym), .rx_sym_vld (rx_sym_vld),
        .rx_word (rx_word), .rx_word_vld (rx_word_vld), .rx_word_err (rx_word_err)
    );

    function automatic int p5(int n);
        int p = 1;
        for (int i = 0; i < n; i++) p = p * 5;
        return p;
    endfunction

    // Behavioural reference model, updated on each rising edge.
    bit m_busy; int m_val; int m_k;
    bit e_svld; int e_sym;
    int r_acc; int r_cnt;
    bit e_wvld; int e_word; bit e_err;
    bit lb_q;
    int sentq[$];

    always @(posedge clk) begin
        int nacc;
        if (!rst_n) begin
            m_busy = 0; m_k = 0; m_val = 0; e_svld = 0; e_sym = 0;
            r_acc = 0; r_cnt = 0; e_wvld = 0; e_word = 0; e_err = 0; lb_q = 0;
        end else begin
            lb_q = lb;
            e_svld = 0;
            if (m_busy) begin
                if (sym_stb) begin
                    e_sym = (m_val / p5(6 - m_k)) % 5;
                    e_svld = 1;
                    if (m_k == 6) m_busy = 0;
                    m_k = m_k + 1;
                end
            end else if (tx_valid) begin
                m_busy = 1; m_k = 0; m_val = int'(tx_data);
                if (lb) sentq.push_back(m_val);
            end
            e_wvld = 0;
            if (rx_resync) begin
                r_acc = 0; r_cnt = 0;
            end else if (rx_sym_vld) begin
                nacc = r_acc * 5 + int'(rx_sym);
                if (r_cnt == 6) begin
                    e_wvld = 1; e_word = nacc % 65536; e_err = (nacc >= 65536);
                    r_acc = 0; r_cnt = 0;
                end else begin
                    r_acc = nacc; r_cnt = r_cnt + 1;
                end
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare outputs with the model shortly after every rising edge.
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            chk(tx_ready == 1'b1, "R10 reset ready", int'(tx_ready), 1);
            chk(tx_sym_vld == 1'b0, "R10 reset sym valid", int'(tx_sym_vld), 0);
            chk(rx_word_vld == 1'b0, "R10 reset word valid", int'(rx_word_vld), 0);
            chk(rx_word_err == 1'b0, "R10 reset err", int'(rx_word_err), 0);
        end else begin
            chk(tx_ready == !m_busy, "R3 ready", int'(tx_ready), int'(!m_busy));
            chk(tx_sym_vld == e_svld, "R4 R5 digit pulse", int'(tx_sym_vld), int'(e_svld));
            if (tx_sym_vld && e_svld) begin
                chk(int'(tx_sym) == e_sym, "R2 digit value", int'(tx_sym), e_sym);
                chk(tx_sym < 3'd5, "R1 digit range", int'(tx_sym), 4);
            end
            chk(rx_word_vld == e_wvld, "R6 R8 word valid", int'(rx_word_vld), int'(e_wvld));
            if (rx_word_vld && e_wvld) begin
                chk(int'(rx_word) == e_word, "R6 word value", int'(rx_word), e_word);
                chk(rx_word_err == e_err, "R7 range flag", int'(rx_word_err), int'(e_err));
                if (rx_word_err) err_seen++;
                if (lb_q) begin
                    if (sentq.size() == 0) begin
                        chk(1'b0, "R9 round trip queue", 1, 0);
                    end else begin
                        int w;
                        w = sentq.pop_front();
                        chk(int'(rx_word) == w && !rx_word_err, "R9 round trip", int'(rx_word), w);
                    end
                end
            end
        end
    end

    // Symbol strobe generator with a programmable period.
    always @(negedge clk) begin
        cyc++;
        sym_stb <= (stb_period != 0) && (cyc % stb_period == 0);
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic send_words(int ws[]);
        foreach (ws[i]) begin
            @(negedge clk);
            tx_valid = 1'b1;
            tx_data = 16'(ws[i]);
            do @(posedge clk); while (!tx_ready);
        end
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic rx_cycle(bit v, int s, bit rs);
        @(negedge clk);
        drv_vld = v;
        drv_sym = 3'(s);
        rx_resync = rs;
    endtask

    task automatic rx_group(int d[7]);
        for (int i = 0; i < 7; i++) begin
            rx_cycle(1'b1, d[i], 1'b0);
            if (i == 3) rx_cycle(1'b0, 0, 1'b0);
        end
        rx_cycle(1'b0, 0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Loopback, strobe every cycle, valid held across words (R3 R4 R9).
        lb = 1'b1;
        stb_period = 1;
        send_words('{0, 65535, 12345, 1, 32768, 4660, 65534});
        repeat (20) @(negedge clk);
        // Sparse strobes, idle strobes between words (R4 R5).
        stb_period = 3;
        send_words('{40000, 777});
        repeat (30) @(negedge clk);
        stb_period = 2;
        send_words('{15625, 78});
        repeat (30) @(negedge clk);
        stb_period = 0;
        repeat (3) @(negedge clk);
        lb = 1'b0;
        // Direct groups: all fours, exactly 65536, 65535 (R7 R6).
        rx_group('{4, 4, 4, 4, 4, 4, 4});
        rx_group('{4, 0, 4, 4, 1, 2, 1});
        rx_group('{4, 0, 4, 4, 1, 2, 0});
        // Partial group then resync (R8).
        rx_cycle(1'b1, 3, 1'b0);
        rx_cycle(1'b1, 2, 1'b0);
        rx_cycle(1'b1, 1, 1'b0);
        rx_cycle(1'b0, 0, 1'b1);
        rx_group('{0, 0, 0, 0, 0, 0, 3});
        // Resync in the same cycle as a would-be seventh digit (R8).
        for (int i = 0; i < 6; i++) rx_cycle(1'b1, 2, 1'b0);
        rx_cycle(1'b1, 2, 1'b1);
        rx_cycle(1'b0, 0, 1'b0);
        rx_group('{1, 2, 3, 4, 0, 1, 2});
        repeat (5) @(negedge clk);
        chk(err_seen == 2, "R7 error count", err_seen, 2);
        chk(sentq.size() == 0, "R9 all words returned", sentq.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule